// File: doc/BRIEF.md
# Packed Byte Sum-of-Absolute-Differences Unit

This execution unit takes two 32-bit operands and treats each one as four unsigned bytes. It pairs the bytes at the same position in the two operands and takes the magnitude of each pair's difference. It then adds the four magnitudes into one 32-bit result. Motion-estimation and block-matching code uses this to score how closely two pixel rows match with a single operation.

Each issued operation carries a guard word and a destination register tag. Only the least significant bit of the guard decides whether the register file receives the result. An unguarded operation is issued with the guard tied to 1. The unit has two register stages. The first stage holds the per-byte magnitudes. The second stage holds the total, the write strobe and the tag. A result therefore leaves the unit exactly two clock edges after issue, and a new operation can enter on every cycle.

Top module: `sad_unit`

## Requirements
- R1: Each operand is split into byte lanes at bits 7:0, 15:8, 23:16 and 31:24. Each byte is read as unsigned (0..255) and paired with the byte at the same position in the other operand. For example, 0x80808080 against 0x7f7f7f7f gives 4.
- R2: Each lane contributes the magnitude of its difference, so swapping the operands gives the same result. 0x64649c9c against 0x649c649c gives 0x70 in both orders.
- R3: The four magnitudes are added with no truncation. The largest total, 1020, comes from 0x00000000 against 0xffffffff. Bits 31:10 of `res_data` are always zero.
- R4: `res_wen` is 1 only when the issue had `issue_vld`=1 and `guard` bit 0 = 1. Guard bits 31:1 have no effect. When bit 0 is 0, no write is signalled.
- R5: An operation sampled on rising edge k shows its `res_data`, `res_tag` and `res_wen` after rising edge k+1, and those values hold until edge k+2.
- R6: Operations may issue on consecutive cycles. Each result comes out in issue order, one per cycle, with its own tag.
- R7: While `rst` is high, and for the two edges after it falls, `res_wen` stays 0 even if `issue_vld` was high during reset.
- R8: 0x0a14f6f6 against 0x1414ecf6 gives 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | An operation is issued this cycle |
| opnd_a | input | 32 | First packed-byte operand |
| opnd_b | input | 32 | Second packed-byte operand |
| guard | input | 32 | Guard word; only bit 0 is used |
| dst_tag | input | 5 | Destination register tag |
| res_data | output | 32 | Sum of absolute byte differences |
| res_tag | output | 5 | Tag carried with the result |
| res_wen | output | 1 | Destination write strobe |

## Verification
The assertions assume that `issue_vld` is a clean 0 or 1 from the first edge on. They also assume that `guard` and `dst_tag` are known whenever an issue is presented, because the tag and write-strobe checks compare outputs with the inputs from two edges earlier. The bench drives every input to a defined value from time zero, including during reset. It changes inputs only on falling edges. Its random stimulus produces fully defined operand and guard words, including random upper guard bits, so that the claim that those bits are ignored is exercised.

// File: rtl/sad_pkg.sv
package sad_pkg;

    localparam int WORD_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int SUM_W  = LANE_W + $clog2(LANES);
    localparam int TAG_W  = 5;

    typedef logic [LANE_W-1:0] lane_t;
    typedef lane_t [LANES-1:0] lane_vec_t;
    typedef logic [SUM_W-1:0]  sum_t;
    typedef logic [TAG_W-1:0]  tag_t;

    // First stage: per-lane magnitudes plus control carried alongside
    typedef struct packed {
        logic      vld;
        logic      wen;
        tag_t      tag;
        lane_vec_t mag;
    } stage1_t;

    // Second stage: reduced total plus control
    typedef struct packed {
        logic wen;
        tag_t tag;
        sum_t total;
    } stage2_t;

    function automatic lane_t lane_of(input logic [WORD_W-1:0] w, input int idx);
        return w[idx*LANE_W +: LANE_W];
    endfunction

    function automatic lane_t abs_gap(input lane_t x, input lane_t y);
        return (x >= y) ? lane_t'(x - y) : lane_t'(y - x);
    endfunction

endpackage

// File: rtl/sad_lane_absdiff.sv
module sad_lane_absdiff
    import sad_pkg::*;
(
    input  lane_t x_i,
    input  lane_t y_i,
    output lane_t mag_o
);
    // Unsigned comparison: both lanes are zero-extended by type
    assign mag_o = abs_gap(x_i, y_i);
endmodule

// File: rtl/sad_lane_reduce.sv
module sad_lane_reduce
    import sad_pkg::*;
(
    input  lane_vec_t mag_i,
    output sum_t      total_o
);
    always_comb begin
        total_o = '0;
        for (int i = 0; i < LANES; i++) begin
            total_o = total_o + sum_t'(mag_i[i]);
        end
    end
endmodule

// File: rtl/sad_unit.sv
module sad_unit
    import sad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_vld,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic [WORD_W-1:0] guard,
    input  logic [TAG_W-1:0]  dst_tag,
    output logic [WORD_W-1:0] res_data,
    output logic [TAG_W-1:0]  res_tag,
    output logic              res_wen
);
    lane_vec_t mag_d;
    sum_t      total_d;
    stage1_t   s1_q;
    stage2_t   s2_q;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            sad_lane_absdiff lane_i (
                .x_i  (lane_of(opnd_a, g)),
                .y_i  (lane_of(opnd_b, g)),
                .mag_o(mag_d[g])
            );
        end
    endgenerate

    // Stage 1: register magnitudes; control bits reset, data does not
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q.vld <= 1'b0;
            s1_q.wen <= 1'b0;
        end else begin
            s1_q.vld <= issue_vld;
            s1_q.wen <= issue_vld & guard[0];
        end
        s1_q.tag <= dst_tag;
        s1_q.mag <= mag_d;
    end

    sad_lane_reduce reduce_i (
        .mag_i  (s1_q.mag),
        .total_o(total_d)
    );

    // Stage 2: register the total and the guarded strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q.wen <= 1'b0;
        end else begin
            s2_q.wen <= s1_q.vld & s1_q.wen;
        end
        s2_q.tag   <= s1_q.tag;
        s2_q.total <= total_d;
    end

    assign res_data = {{(WORD_W-SUM_W){1'b0}}, s2_q.total};
    assign res_tag  = s2_q.tag;
    assign res_wen  = s2_q.wen;
endmodule

// File: rtl/sad_unit_chk.sv
module sad_unit_chk
    import sad_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              issue_vld,
    input logic [WORD_W-1:0] guard,
    input logic [TAG_W-1:0]  dst_tag,
    input logic [WORD_W-1:0] res_data,
    input logic [TAG_W-1:0]  res_tag,
    input logic              res_wen
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R3: the total never reaches bit 10
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        res_data[WORD_W-1:SUM_W] == '0);

    // R4: the strobe follows guard bit 0 of the issue two edges earlier
    a_r4_guarded_write: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (res_wen == $past(issue_vld & guard[0], 2)));

    // R5: the tag travels with the result
    a_r5_tag_follows: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && res_wen) |-> (res_tag == $past(dst_tag, 2)));

    // R7: no write drains out of the pipe just after reset
    a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 2'd2) |-> !res_wen);
endmodule

bind sad_unit sad_unit_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .issue_vld(issue_vld),
    .guard    (guard),
    .dst_tag  (dst_tag),
    .res_data (res_data),
    .res_tag  (res_tag),
    .res_wen  (res_wen)
);

// File: tb/sad_unit_tb_top.sv
module sad_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_vld = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] guard = '0;
    logic [4:0]  dst_tag = '0;
    logic [31:0] res_data;
    logic [4:0]  res_tag;
    logic        res_wen;

    int vectors = 0;
    int miscompares = 0;
    int step_n = 0;
    bit done = 1'b0;

    // Ring of expectations, indexed by issue step
    logic        e_vld [4];
    logic        e_wen [4];
    logic [31:0] e_dat [4];
    logic [4:0]  e_tag [4];
    string       e_req [4];

    always #2 clk = ~clk;

    sad_unit dut_i (
        .clk(clk), .rst(rst), .issue_vld(issue_vld),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .guard(guard), .dst_tag(dst_tag),
        .res_data(res_data), .res_tag(res_tag), .res_wen(res_wen)
    );

    function automatic logic [31:0] model_sad(input logic [31:0] a, input logic [31:0] b);
        int acc = 0;
        for (int i = 0; i < 4; i++) begin
            int x = int'(a[i*8 +: 8]);
            int y = int'(b[i*8 +: 8]);
            acc += (x > y) ? x - y : y - x;
        end
        return 32'(acc);
    endfunction

    task automatic check_slot(input int s);
        vectors++;
        if (res_wen !== e_wen[s]) begin
            miscompares++;
            $display("FAIL %s wen: got %0b expected %0b", e_req[s], res_wen, e_wen[s]);
        end
        if (e_vld[s]) begin
            vectors++;
            if (res_data !== e_dat[s]) begin
                miscompares++;
                $display("FAIL %s data: got 0x%08h expected 0x%08h", e_req[s], res_data, e_dat[s]);
            end
            vectors++;
            if (res_tag !== e_tag[s]) begin
                miscompares++;
                $display("FAIL %s tag: got %0d expected %0d", e_req[s], res_tag, e_tag[s]);
            end
        end
    endtask

    // One cycle: check the issue from two steps back, then drive a new one
    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] g, input logic [4:0] t, input string req);
        int s;
        @(negedge clk);
        check_slot((step_n + 2) % 4);
        s = step_n % 4;
        e_vld[s] = v;
        e_wen[s] = v & g[0];
        e_dat[s] = model_sad(a, b);
        e_tag[s] = t;
        e_req[s] = req;
        issue_vld = v; opnd_a = a; opnd_b = b; guard = g; dst_tag = t;
        step_n++;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5ad0_1234));
        // R7: the first two checks expect no write drained from reset
        for (int i = 0; i < 4; i++) begin
            e_vld[i] = 1'b0; e_wen[i] = 1'b0; e_dat[i] = '0; e_tag[i] = '0; e_req[i] = "R7";
        end
        issue_vld = 1'b1; guard = 32'h1; opnd_a = 32'hffffffff;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; issue_vld = 1'b0;
        step(1'b0, 0, 0, 0, 0, "R7");

        // R8 and R1 examples
        step(1'b1, 32'h0a14f6f6, 32'h1414ecf6, 32'h1, 5'd1, "R8");
        step(1'b1, 32'h80808080, 32'h7f7f7f7f, 32'h1, 5'd2, "R1");
        // R2: operand order does not matter
        step(1'b1, 32'h64649c9c, 32'h649c649c, 32'h1, 5'd3, "R2");
        step(1'b1, 32'h649c649c, 32'h64649c9c, 32'h1, 5'd4, "R2");
        // R3: extreme totals
        step(1'b1, 32'h00000000, 32'hffffffff, 32'h1, 5'd5, "R3");
        step(1'b1, 32'hffffffff, 32'h00000000, 32'h1, 5'd6, "R3");
        step(1'b1, 32'h12345678, 32'h12345678, 32'h1, 5'd7, "R3");
        // R4: upper guard bits ignored, bit 0 decides
        step(1'b1, 32'h01020304, 32'h04030201, 32'hfffffffe, 5'd8, "R4");
        step(1'b1, 32'h01020304, 32'h04030201, 32'h00000001, 5'd9, "R4");
        step(1'b1, 32'hdeadbeef, 32'h0badf00d, 32'h80000000, 5'd10, "R4");
        // R5: single issue among idle cycles
        step(1'b0, 32'h11111111, 32'h22222222, 32'h1, 5'd11, "R5");
        step(1'b1, 32'h0000ff00, 32'h00000000, 32'h1, 5'd12, "R5");
        step(1'b0, 0, 0, 0, 0, "R5");
        step(1'b0, 0, 0, 0, 0, "R5");
        // R6: back-to-back random stream with mixed guards and idles
        for (int k = 0; k < 400; k++) begin
            logic v;
            v = ($urandom % 5) != 0;
            step(v, $urandom, $urandom, $urandom, 5'($urandom), "R6");
        end
        step(1'b0, 0, 0, 0, 0, "R6");
        step(1'b0, 0, 0, 0, 0, "R6");
        step(1'b0, 0, 0, 0, 0, "R6");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule